// File: doc/BRIEF.md
# Multichannel ADC Sequencer with Window Watchdog

This block is the digital controller for a 16-input, 10-bit successive-approximation converter. Software programs a first channel, a prescaler and a watchdog window, then pulses `start`. The sequencer drives the channel number and the sample and convert phase enables to the analog core. For each channel it holds the sample phase for 8 converter clock ticks and the convert phase for 20 ticks, then latches the 10-bit result from the core. It repeats this for every channel from the first channel up to channel 15 and raises an end-of-run flag.

Each result is kept left-justified as a 16-bit value over two byte registers. Two neighbouring channels, picked by software, are checked against a high and a low 10-bit threshold. A result outside that window sets a sticky watchdog flag. Both flags drive one interrupt line, and each flag has its own enable.

Register map (byte addresses on a 6-bit bus): channel `c` result high byte at `2c`, low byte at `2c+1`; `0x20` sequence setup (bits 7:4 first channel, bits 3:0 first watchdog channel); `0x21` clock setup (bits 7:5 prescaler); `0x22`/`0x23` high threshold high/low byte; `0x24`/`0x25` low threshold high/low byte; `0x26` interrupt enables (bit 0 end-of-run, bit 1 watchdog); `0x27` flags (bit 0 end-of-run, bit 1 watchdog, write 1 to clear). All other addresses read as zero.

Top module: `adc_sequencer`

## Requirements
- R1: After reset all result registers, both flags and `irq` read zero, and `sampleEn` and `convertEn` are low.
- R2: A `start` pulse in idle converts the channels from the first channel (bits 7:4 of `0x20`) up to channel 15 in ascending order. Channels below the first channel keep their previous results.
- R3: For each channel, `sampleEn` is high for exactly 8 converter ticks and is then followed by `convertEn` high for exactly 20 ticks. The two are never high together, and `chanSel` holds the channel number throughout.
- R4: One converter tick lasts 2*(P+1) clock cycles, where P is bits 7:5 of `0x21`. The end-of-run flag becomes visible 28*(16-S)*2*(P+1) clock cycles after the clock edge that samples `start`, where S is the first channel.
- R5: A result R is latched from `convResult` at the end of the convert phase. The high byte reads R[9:2]. The low byte reads R[1:0] in bits 7:6, with bits 5:0 zero.
- R6: The end-of-run flag (`0x27` bit 0) is set when channel 15 finishes. `irq` reflects it only while enable bit 0 of `0x26` is set.
- R7: The watched channels are W and (W+1) mod 16, where W is bits 3:0 of `0x20`. A watched result that is strictly above the high threshold or strictly below the low threshold sets the sticky watchdog flag (`0x27` bit 1). A result equal to either threshold does not set it.
- R8: `irq` is the OR of each flag ANDed with its enable. Writing 1 to a flag bit of `0x27` clears only that flag.
- R9: A `start` pulse while a run is in progress is ignored, and the run length is unchanged.
- R10: Thresholds are 10-bit values. The high register byte holds bits 9:2, and the low register byte holds bits 1:0 in bits 7:6. The low byte reads back with bits 5:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 6 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| start | input | 1 | Start-of-run strobe |
| convResult | input | 10 | Result from the analog core |
| chanSel | output | 4 | Channel selected at the analog core |
| sampleEn | output | 1 | Sample phase active |
| convertEn | output | 1 | Convert phase active |
| irq | output | 1 | Interrupt request |

## Verification
A wrong phase or divider count shows up at the ports on the first channel of a run. The widths of the `sampleEn` and `convertEn` pulses and the end-of-run latency then miss 8, 20 and 28 ticks by whole cycles. A wrong channel counter or result latch shows up as a result written to the wrong byte pair, or as lost earlier results, as soon as the run ends. A wrong watchdog pair, comparison or flag clear shows up in `irq` and the flag byte right after the run. The equal-to-threshold case and the pair that wraps from channel 15 to channel 0 are covered.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CHANNELS = 16;
  localparam int CH_W = $clog2(NUM_CHANNELS);
  localparam int RES_W = 10;
  localparam int ADDR_W = CH_W + 2;
  localparam int SAMPLE_TICKS = 8;
  localparam int CONV_TICKS = 20;
  localparam int PRESC_W = 3;

  localparam logic [ADDR_W-1:0] A_SEQ   = ADDR_W'(2 * NUM_CHANNELS + 0);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(2 * NUM_CHANNELS + 1);
  localparam logic [ADDR_W-1:0] A_THI_H = ADDR_W'(2 * NUM_CHANNELS + 2);
  localparam logic [ADDR_W-1:0] A_THI_L = ADDR_W'(2 * NUM_CHANNELS + 3);
  localparam logic [ADDR_W-1:0] A_TLO_H = ADDR_W'(2 * NUM_CHANNELS + 4);
  localparam logic [ADDR_W-1:0] A_TLO_L = ADDR_W'(2 * NUM_CHANNELS + 5);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(2 * NUM_CHANNELS + 6);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2 * NUM_CHANNELS + 7);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} seqState_e;

  // strobes from sequencing control to the register datapath
  typedef struct packed {
    logic            capture;
    logic            runDone;
    logic [CH_W-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SAMP_T = SAMPLE_TICKS,
  parameter int CONV_T = CONV_TICKS,
  parameter int PW     = PRESC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CH_W-1:0] startCh,
  input  logic [PW-1:0]   presc,
  output logic            sampleEn,
  output logic            convertEn,
  output logic [CH_W-1:0] chanSel,
  output seqStrobe_t      stb
);
  localparam int DIV_MAX = 2 * (1 << PW);
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam int PH_MAX  = (SAMP_T > CONV_T) ? SAMP_T : CONV_T;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  seqState_e        state;
  logic [CH_W-1:0]  chan;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [PH_W-1:0]  phaseCnt;
  logic             tick;
  logic             sampDone;
  logic             convDone;
  logic             lastChan;

  assign divLimit = (DIV_W'(presc) + DIV_W'(1)) << 1;
  assign tick     = (divCnt == divLimit - DIV_W'(1));
  assign sampDone = (state == ST_SAMP) && tick && (phaseCnt == PH_W'(SAMP_T - 1));
  assign convDone = (state == ST_CONV) && tick && (phaseCnt == PH_W'(CONV_T - 1));
  assign lastChan = (chan == CH_W'(NUM_CHANNELS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chan     <= '0;
      divCnt   <= '0;
      phaseCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_SAMP;
            chan     <= startCh;
            divCnt   <= '0;
            phaseCnt <= '0;
          end
        end
        ST_SAMP: begin
          divCnt <= tick ? '0 : divCnt + DIV_W'(1);
          if (sampDone) begin
            state    <= ST_CONV;
            phaseCnt <= '0;
          end else if (tick) begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        ST_CONV: begin
          divCnt <= tick ? '0 : divCnt + DIV_W'(1);
          if (convDone) begin
            phaseCnt <= '0;
            if (lastChan) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_SAMP;
              chan  <= chan + CH_W'(1);
            end
          end else if (tick) begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sampleEn    = (state == ST_SAMP);
  assign convertEn   = (state == ST_CONV);
  assign chanSel     = chan;
  assign stb.capture = convDone;
  assign stb.runDone = convDone && lastChan;
  assign stb.chan    = chan;
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int PW = PRESC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [RES_W-1:0]  convResult,
  input  seqStrobe_t        stb,
  output logic [CH_W-1:0]   startCh,
  output logic [PW-1:0]     presc,
  output logic              irq
);
  logic [RES_W-1:0] resMem [NUM_CHANNELS];
  logic [CH_W-1:0]  wdCh;
  logic [RES_W-1:0] thrHi;
  logic [RES_W-1:0] thrLo;
  logic             eocIe;
  logic             wdIe;
  logic             eocFlag;
  logic             wdFlag;
  logic             watched;
  logic             outside;
  logic             wdHit;
  logic             statWr;
  logic [CH_W-1:0]  rdCh;

  assign watched = (stb.chan == wdCh) || (stb.chan == wdCh + CH_W'(1));
  assign outside = (convResult > thrHi) || (convResult < thrLo);
  assign wdHit   = stb.capture && watched && outside;
  assign statWr  = wrEn && (wrAddr == A_STAT);

  // result store, one slot per channel
  for (genvar g = 0; g < NUM_CHANNELS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resMem[g] <= '0;
      else if (stb.capture && stb.chan == CH_W'(g)) resMem[g] <= convResult;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCh <= '0;
      wdCh    <= '0;
      presc   <= '0;
      thrHi   <= '0;
      thrLo   <= '0;
      eocIe   <= 1'b0;
      wdIe    <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        A_SEQ: begin
          startCh <= wrData[7:4];
          wdCh    <= wrData[3:0];
        end
        A_CLK:   presc <= wrData[7:8-PW];
        A_THI_H: thrHi[RES_W-1:2] <= wrData;
        A_THI_L: thrHi[1:0] <= wrData[7:6];
        A_TLO_H: thrLo[RES_W-1:2] <= wrData;
        A_TLO_L: thrLo[1:0] <= wrData[7:6];
        A_IEN: begin
          eocIe <= wrData[0];
          wdIe  <= wrData[1];
        end
        default: ;
      endcase
    end
  end

  // sticky flags: a hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocFlag <= 1'b0;
      wdFlag  <= 1'b0;
    end else begin
      if (stb.runDone)               eocFlag <= 1'b1;
      else if (statWr && wrData[0])  eocFlag <= 1'b0;
      if (wdHit)                     wdFlag  <= 1'b1;
      else if (statWr && wrData[1])  wdFlag  <= 1'b0;
    end
  end

  assign irq  = (eocFlag && eocIe) || (wdFlag && wdIe);
  assign rdCh = rdAddr[CH_W:1];

  always_comb begin
    rdData = 8'h00;
    if (!rdAddr[ADDR_W-1]) begin
      if (rdAddr[0]) rdData = {resMem[rdCh][1:0], 6'b0};
      else           rdData = resMem[rdCh][RES_W-1:2];
    end else begin
      case (rdAddr)
        A_SEQ:   rdData = {startCh, wdCh};
        A_CLK:   rdData = {presc, {(8-PW){1'b0}}};
        A_THI_H: rdData = thrHi[RES_W-1:2];
        A_THI_L: rdData = {thrHi[1:0], 6'b0};
        A_TLO_H: rdData = thrLo[RES_W-1:2];
        A_TLO_L: rdData = {thrLo[1:0], 6'b0};
        A_IEN:   rdData = {6'b0, wdIe, eocIe};
        A_STAT:  rdData = {6'b0, wdFlag, eocFlag};
        default: rdData = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              start,
  input  logic [RES_W-1:0]  convResult,
  output logic [CH_W-1:0]   chanSel,
  output logic              sampleEn,
  output logic              convertEn,
  output logic              irq
);
  seqStrobe_t         seqStb;
  logic [CH_W-1:0]    startCh;
  logic [PRESC_W-1:0] presc;

  adc_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .startCh(startCh), .presc(presc),
    .sampleEn(sampleEn), .convertEn(convertEn), .chanSel(chanSel), .stb(seqStb)
  );

  adc_seq_dpath dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .convResult(convResult), .stb(seqStb),
    .startCh(startCh), .presc(presc), .irq(irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            sampleEn,
  input logic            convertEn,
  input logic [CH_W-1:0] chanSel,
  input seqStrobe_t      stb
);
  // R3
  phase_mutex_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEn && convertEn));

  // R3
  conv_after_samp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convertEn) |-> $past(sampleEn));

  // R3
  capture_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> convertEn && stb.chan == chanSel);

  // R2
  chan_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sampleEn) && $past(convertEn)) |-> chanSel == $past(chanSel) + CH_W'(1));

  // R2
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.runDone |-> chanSel == CH_W'(NUM_CHANNELS - 1));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sampleEn) && convertEn) |-> $stable(chanSel));
endmodule

bind adc_sequencer adc_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .convertEn(convertEn),
  .chanSel(chanSel), .stb(seqStb)
);

// File: tb/adc_sequencer_tb.sv
module adc_sequencer_tb_top;
  import adc_seq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              start = 1'b0;
  logic [RES_W-1:0]  convResult;
  logic [CH_W-1:0]   chanSel;
  logic              sampleEn;
  logic              convertEn;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int curDiv = 2;
  logic [RES_W-1:0] expMem [NUM_CHANNELS];

  typedef struct {int ch; logic [RES_W-1:0] val;} item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  function automatic logic [RES_W-1:0] valFn(int ch, int sd);
    return RES_W'((ch * 61 + sd) & 10'h3FF);
  endfunction

  assign convResult = valFn(int'(chanSel), seed);

  adc_sequencer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .start(start), .convResult(convResult),
    .chanSel(chanSel), .sampleEn(sampleEn), .convertEn(convertEn), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // monitor: phase widths and scoreboard pop at each capture
  initial begin
    int sCnt = 0;
    int cCnt = 0;
    forever begin
      @(negedge clk);
      if (sampleEn) sCnt++;
      else if (sCnt > 0) begin
        chk(sCnt == SAMPLE_TICKS * curDiv, "R3/R4 sample width", sCnt, SAMPLE_TICKS * curDiv);
        sCnt = 0;
      end
      if (convertEn) cCnt++;
      else if (cCnt > 0) begin
        logic [7:0] hi, lo;
        item_t it;
        chk(cCnt == CONV_TICKS * curDiv, "R3/R4 convert width", cCnt, CONV_TICKS * curDiv);
        cCnt = 0;
        if (sbq.size() == 0) chk(1'b0, "R2 unexpected capture", 0, 1);
        else begin
          it = sbq.pop_front();
          rdReg(ADDR_W'(2 * it.ch), hi);
          rdReg(ADDR_W'(2 * it.ch + 1), lo);
          chk(hi == it.val[9:2], "R5 high byte", hi, it.val[9:2]);
          chk(lo == {it.val[1:0], 6'b0}, "R5 low byte", lo, {it.val[1:0], 6'b0});
        end
      end
    end
  end

  // driver: program, push expectations, run and time the end-of-run flag
  task automatic runSeq(input int s, input int p, input int sd, input int extraAt,
                        output bit wdExp, input int wdc, input int hi, input int lo);
    int n;
    int nExp;
    seed = sd;
    curDiv = 2 * (p + 1);
    wdExp = 1'b0;
    wrReg(A_SEQ, {4'(s), 4'(wdc)});
    wrReg(A_CLK, {3'(p), 5'b0});
    for (int c = s; c < NUM_CHANNELS; c++) begin
      item_t it;
      it.ch = c; it.val = valFn(c, sd);
      sbq.push_back(it);
      expMem[c] = it.val;
      if ((c == wdc || c == ((wdc + 1) % NUM_CHANNELS)) && (int'(it.val) > hi || int'(it.val) < lo))
        wdExp = 1'b1;
    end
    nExp = 28 * (NUM_CHANNELS - s) * curDiv;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < nExp + 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (extraAt > 0 && n == extraAt);
      if (irq) break;
    end
    start = 1'b0;
    chk(n == nExp, (extraAt > 0) ? "R9 run length with extra start" : "R4/R6 end-of-run latency", n, nExp);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R2 all channels converted", sbq.size(), 0);
  endtask

  task automatic cmpAll(input string tag);
    for (int c = 0; c < NUM_CHANNELS; c++) begin
      logic [7:0] h, l;
      rdReg(ADDR_W'(2 * c), h);
      rdReg(ADDR_W'(2 * c + 1), l);
      chk(h == expMem[c][9:2] && l == {expMem[c][1:0], 6'b0}, tag, {h, l}, {expMem[c][9:2], expMem[c][1:0], 6'b0});
    end
  endtask

  task automatic setThr(input int hi, input int lo);
    wrReg(A_THI_H, 8'(hi >> 2)); wrReg(A_THI_L, {2'(hi), 6'b0});
    wrReg(A_TLO_H, 8'(lo >> 2)); wrReg(A_TLO_L, {2'(lo), 6'b0});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit wdExp;
    for (int c = 0; c < NUM_CHANNELS; c++) expMem[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(A_STAT, d);
    chk(d == 8'h00, "R1 flags after reset", d, 0);
    chk(!irq && !sampleEn && !convertEn, "R1 outputs after reset", {irq, sampleEn, convertEn}, 0);
    cmpAll("R1 results after reset");

    // R10 threshold layout
    setThr(10'h2AF, 10'h13D);
    rdReg(A_THI_H, d); chk(d == 8'hAB, "R10 high threshold high byte", d, 8'hAB);
    rdReg(A_THI_L, d); chk(d == 8'hC0, "R10 high threshold low byte", d, 8'hC0);
    rdReg(A_TLO_L, d); chk(d == 8'h40, "R10 low threshold low byte", d, 8'h40);

    // run A: whole sweep, watched channel 4 below the window (R7)
    setThr(10'h300, 10'h100);
    wrReg(A_IEN, 8'h01);
    runSeq(0, 0, 5, 0, wdExp, 4, 10'h300, 10'h100);
    cmpAll("R5 results run A");
    rdReg(A_STAT, d);
    chk(d == {6'b0, wdExp, 1'b1}, "R6/R7 flags run A", d, {6'b0, wdExp, 1'b1});

    // R8: clear both flags with write-one
    wrReg(A_STAT, 8'h03);
    rdReg(A_STAT, d); chk(d == 8'h00, "R8 clear both flags", d, 0);
    chk(!irq, "R8 irq low after clear", irq, 0);

    // run B: partial sweep, watched pair exactly on the thresholds (R7 boundary)
    setThr(993, 932);
    runSeq(12, 2, 200, 0, wdExp, 12, 993, 932);
    cmpAll("R2 lower channels kept run B");
    rdReg(A_STAT, d);
    chk(d == 8'h01, "R7 equal-to-threshold no flag", d, 8'h01);
    wrReg(A_STAT, 8'h01);

    // run C: single channel, wrapped pair 15/0, extra start ignored (R9)
    setThr(10'h3FF, 916);
    wrReg(A_IEN, 8'h03);
    runSeq(15, 1, 0, 100, wdExp, 15, 10'h3FF, 916);
    rdReg(A_STAT, d);
    chk(d == {6'b0, wdExp, 1'b1}, "R7 wrapped pair flag", d, {6'b0, wdExp, 1'b1});
    cmpAll("R9 results after extra start");

    // R8: clear only end-of-run, then gate the watchdog flag
    wrReg(A_STAT, 8'h01);
    rdReg(A_STAT, d); chk(d == 8'h02, "R8 selective clear", d, 8'h02);
    chk(irq, "R8 irq from watchdog flag", irq, 1);
    wrReg(A_IEN, 8'h01);
    chk(!irq, "R8 watchdog flag gated", irq, 0);
    wrReg(A_IEN, 8'h00);
    chk(!sampleEn && !convertEn, "R9 idle after run", {sampleEn, convertEn}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule